// File: doc/BRIEF.md
# Burst Repetition Sequencer

This block sits between a trigger source and a periodic waveform player. It decides when the player may run. A trigger starts a sequence made of bursts. In each burst the player runs for a set number of complete waveform periods. The sequencer learns that a period has finished from a single-cycle pulse sent by the phase accumulator. After each burst except the last, the run-enable output drops for an idle gap measured in microseconds. While run-enable is low, the player holds its output at zero and reloads its start phase. When the last burst ends, a done flag rises and stays up.

Three 32-bit configuration words are sampled when a trigger is accepted:
- the number of periods in each burst (zero means the burst never ends);
- the number of bursts (zero means burst mode is off and the player runs freely);
- the gap length in microseconds.

A clock prescaler of `TICK_DIV` cycles makes the microsecond tick. The default of 125 suits a 125 MHz clock.

Top module: `burst_seq`

## Requirements
- R1: While reset is applied and just after it is released, `run_o` and `done_o` are both 0.
- R2: A trigger sampled while idle or done, with a non-zero burst count, makes `run_o` 1 and `done_o` 0 from the next cycle on.
- R3: With a non-zero period count N, `run_o` falls right after the clock edge that samples the N-th `period_done_i` pulse of the burst.
- R4: Between two bursts with a gap of D microseconds, `run_o` stays 0 for exactly D*TICK_DIV clock cycles. Then the next burst starts.
- R5: After the programmed number of bursts, `run_o` is 0 and `done_o` is 1. No gap follows the last burst.
- R6: `done_o` stays 1 until a new trigger is accepted or reset is applied. An accepted trigger restarts the sequence.
- R7: A period count of 0 keeps `run_o` at 1 for any number of `period_done_i` pulses.
- R8: A burst count of 0 at the trigger puts the block into free running. `run_o` stays 1 and `done_o` stays 0 until reset, whatever the triggers and pulses.
- R9: Triggers that arrive while a sequence is running or in a gap are ignored. Changes to the configuration inputs after a trigger has no effect until the next accepted trigger.
- R10: With a gap of 0, one burst follows the next without `run_o` dropping. The periods of the bursts are still counted per burst.
- R11: `period_done_i` pulses while idle, in a gap or done are not counted toward any burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| trig_i | input | 1 | Start request, sampled each cycle |
| period_done_i | input | 1 | Single-cycle pulse at each completed waveform period |
| cfg_cycles_i | input | 32 | Periods per burst, 0 = endless |
| cfg_bursts_i | input | 32 | Number of bursts, 0 = free running |
| cfg_delay_i | input | 32 | Gap between bursts in microseconds |
| run_o | output | 1 | Player enable; when low the output is zero and the phase is reloaded |
| done_o | output | 1 | Sequence finished |

## Verification
The bench runs every combination of 1 to 3 periods, 1 to 3 bursts, 0 to 2 microseconds of gap, and a pulse spacing of 1 to 3 clocks. It computes the expected enable and done levels for every cycle from these numbers.

Several faults would show up as a shift in timing:
- A design that counts pulses during a gap would start later bursts too early.
- An off-by-one in the prescaler would make every gap a multiple of the wrong length.
- A design that inserts a gap after the final burst would raise done too late.

Other runs are aimed at specific faults:
- Stray triggers and garbage configuration values are applied mid-sequence. A design that accepts them would restart or change the burst length.
- The zero-period and zero-burst settings are checked over long windows. A design that treats zero as a limit would stop after a wrap or raise done.

// File: rtl/bst_pkg.sv
package bst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RUN  = 3'd1,
    ST_GAP  = 3'd2,
    ST_DONE = 3'd3,
    ST_FREE = 3'd4
  } bst_state_e;

endpackage

// File: rtl/bst_rst_sync.sv
module bst_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_ni = sync_q;

endmodule

// File: rtl/bst_tick_div.sv
module bst_tick_div #(
  parameter int unsigned DIV = 125
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);

  localparam int unsigned TW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [TW-1:0] LAST = TW'(DIV - 1);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;

  assign tick_o = en_i && (cnt_q == LAST);

  always_comb begin
    if (!en_i || tick_o) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

endmodule

// File: rtl/bst_event_cnt.sv
module bst_event_cnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] limit_i,
  output logic         hit_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  // a zero limit never hits: the count runs on without end
  assign hit_o  = inc_i && (limit_i != '0) && (cnt_q == limit_i - 1'b1);
  assign cnt_en = clr_i || inc_i;

  always_comb begin
    if (clr_i || hit_o) cnt_d = '0;
    else                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (limit_i != '0) |-> (cnt_q < limit_i));

endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import bst_pkg::*;
#(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned TICK_DIV = 125
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             period_done_i,
  input  logic [CNT_W-1:0] cfg_cycles_i,
  input  logic [CNT_W-1:0] cfg_bursts_i,
  input  logic [CNT_W-1:0] cfg_delay_i,
  output logic             run_o,
  output logic             done_o
);

  logic             rst_ni;
  bst_state_e       state_q;
  bst_state_e       state_d;
  logic [CNT_W-1:0] cyc_lim_q;
  logic [CNT_W-1:0] bst_lim_q;
  logic [CNT_W-1:0] dly_lim_q;
  logic             accept;
  logic             cyc_hit;
  logic             bst_hit;
  logic             us_tick;
  logic             dly_hit;
  logic             in_run;
  logic             in_gap;

  bst_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ni (rst_ni)
  );

  assign in_run = (state_q == ST_RUN);
  assign in_gap = (state_q == ST_GAP);
  assign accept = trig_i && ((state_q == ST_IDLE) || (state_q == ST_DONE));

  // periods within the current burst
  bst_event_cnt #(.W(CNT_W)) u_cyc (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .clr_i   (!in_run),
    .inc_i   (in_run && period_done_i),
    .limit_i (cyc_lim_q),
    .hit_o   (cyc_hit)
  );

  // bursts within the sequence
  bst_event_cnt #(.W(CNT_W)) u_bst (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .clr_i   (accept),
    .inc_i   (cyc_hit),
    .limit_i (bst_lim_q),
    .hit_o   (bst_hit)
  );

  bst_tick_div #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_ni (rst_ni),
    .en_i   (in_gap),
    .tick_o (us_tick)
  );

  // microseconds within the gap
  bst_event_cnt #(.W(CNT_W)) u_dly (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .clr_i   (!in_gap),
    .inc_i   (us_tick),
    .limit_i (dly_lim_q),
    .hit_o   (dly_hit)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (accept) state_d = (cfg_bursts_i == '0) ? ST_FREE : ST_RUN;
      end
      ST_RUN: begin
        if (cyc_hit) begin
          if (bst_hit)                state_d = ST_DONE;
          else if (dly_lim_q == '0)   state_d = ST_RUN;
          else                        state_d = ST_GAP;
        end
      end
      ST_GAP: begin
        if (dly_hit) state_d = ST_RUN;
      end
      ST_FREE: state_d = ST_FREE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_lim_q <= '0;
      bst_lim_q <= '0;
      dly_lim_q <= '0;
    end else if (accept) begin
      cyc_lim_q <= cfg_cycles_i;
      bst_lim_q <= cfg_bursts_i;
      dly_lim_q <= cfg_delay_i;
    end
  end

  assign run_o  = in_run || (state_q == ST_FREE);
  assign done_o = (state_q == ST_DONE);

  // R2
  run_start_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(run_o) |-> ($past(trig_i) || $past(state_q == ST_GAP)));

  // R5
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(done_o) |-> $past(period_done_i));

  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (done_o && !trig_i) |=> done_o);

  // R9
  cfg_freeze_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q != ST_IDLE && state_q != ST_DONE)
      |=> ($stable(cyc_lim_q) && $stable(bst_lim_q) && $stable(dly_lim_q)));

  // R8
  free_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_FREE) |=> (run_o && !done_o));

endmodule

// File: tb/burst_seq_tb.sv
module burst_seq_tb;

  localparam int CLK_PERIOD = 8;
  localparam int DIV        = 4;

  logic        clk;
  logic        rst_n;
  logic        trig;
  logic        pd;
  logic [31:0] cyc;
  logic [31:0] bst;
  logic [31:0] dly;
  logic        run_o;
  logic        done_o;

  int checks   = 0;
  int failures = 0;

  burst_seq #(.CNT_W(32), .TICK_DIV(DIV)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .trig_i        (trig),
    .period_done_i (pd),
    .cfg_cycles_i  (cyc),
    .cfg_bursts_i  (bst),
    .cfg_delay_i   (dly),
    .run_o         (run_o),
    .done_o        (done_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0; trig = 1'b0; pd = 1'b0;
    repeat (3) @(negedge clk);
    chk(run_o == 1'b0, "R1", "run in reset", run_o, 0);
    chk(done_o == 1'b0, "R1", "done in reset", done_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(run_o == 1'b0, "R1", "run after reset", run_o, 0);
    chk(done_o == 1'b0, "R1", "done after reset", done_o, 0);
  endtask

  // one full sequence with C periods, B bursts, D us gap, pulse every P clocks
  task automatic sweep(input int c, input int b, input int d, input int p);
    int l;
    int donek;
    l     = c * p + d * DIV;
    donek = (b - 1) * l + c * p;
    @(negedge clk);
    trig = 1'b1; pd = 1'b0;
    cyc = 32'(c); bst = 32'(b); dly = 32'(d);
    for (int k = 0; k <= donek + 3; k++) begin
      bit    exp_done;
      bit    exp_run;
      string tag;
      @(negedge clk);
      exp_done = (k >= donek);
      exp_run  = !exp_done && ((k % l) < c * p);
      if (k == 0)                  tag = "R2";
      else if (exp_done)           tag = "R5";
      else if (!exp_run)           tag = "R4";
      else if (d == 0 && k >= l)   tag = "R10";
      else                         tag = "R3";
      chk(run_o == exp_run, tag, $sformatf("run c%0d b%0d d%0d p%0d k%0d", c, b, d, p, k),
          run_o, exp_run);
      chk(done_o == exp_done, tag, $sformatf("done c%0d b%0d d%0d p%0d k%0d", c, b, d, p, k),
          done_o, exp_done);
      // R9: stray trigger while busy and garbage configuration after the start
      trig = (k == 1) && (donek > 1);
      if (k == 0) begin
        cyc = 32'd7; bst = 32'd5; dly = 32'd3;
      end
      // R11: pulses keep coming in gaps and after done and must be ignored
      pd = (((k % l) + 1) % p) == 0;
    end
    trig = 1'b0; pd = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; trig = 1'b0; pd = 1'b0;
    cyc = '0; bst = '0; dly = '0;
    apply_reset();

    // R11: pulses in idle are not counted toward the first burst
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); pd = 1'b1;
    end
    @(negedge clk); pd = 1'b0;
    chk(run_o == 1'b0, "R11", "run idle after pulses", run_o, 0);

    for (int c = 1; c <= 3; c++)
      for (int b = 1; b <= 3; b++)
        for (int d = 0; d <= 2; d++)
          for (int p = 1; p <= 3; p++)
            sweep(c, b, d, p);

    // R6: done held with no trigger
    repeat (10) @(negedge clk);
    chk(done_o == 1'b1, "R6", "done held", done_o, 1);

    // R7: endless burst
    @(negedge clk);
    trig = 1'b1; cyc = 32'd0; bst = 32'd2; dly = 32'd1;
    @(negedge clk);
    trig = 1'b0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      pd = (i % 2) == 0;
      if (i % 10 == 9) begin
        chk(run_o == 1'b1, "R7", "run endless", run_o, 1);
        chk(done_o == 1'b0, "R7", "done endless", done_o, 0);
      end
    end
    pd = 1'b0;
    apply_reset();

    // R8: burst mode off, free running
    @(negedge clk);
    trig = 1'b1; cyc = 32'd2; bst = 32'd0; dly = 32'd1;
    @(negedge clk);
    trig = 1'b0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      pd   = (i % 3) == 0;
      trig = (i % 17) == 5;
      if (i % 10 == 9) begin
        chk(run_o == 1'b1, "R8", "run free", run_o, 1);
        chk(done_o == 1'b0, "R8", "done free", done_o, 0);
      end
    end
    pd = 1'b0; trig = 1'b0;
    apply_reset();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule